// File: doc/BRIEF.md
# Ping-Pong Buffer Channel Tracker

This block keeps the per-channel bookkeeping for a DMA channel that works through two alternating buffer descriptor slots. A producer posts buffers with an address and a byte size. The tracker checks the size against the channel's transfer type. When the size is valid and a slot is free, it emits a one-cycle programming pulse for the slot whose turn it is. The DMA engine reports each finished slot on a level-style done bit. The tracker accepts done bits strictly in slot order and answers each accepted one with a clear pulse.

A consumer advances the tracker with service strobes. Each strobe retires one acknowledged completion into a count of finished buffers. The consumer later removes finished buffers from that count in batches with a detach request. The tracker reports a ready flag and the finished-buffer count. It raises one-cycle error pulses for bad sizes, for posting into a full channel, and for retiring or detaching more than exists. Two independent slot pointers, one for submission and one for completion, run alongside a request counter and a service counter.

Top module: `pp_chan_tracker`

## Requirements
- R1: At most two buffers are outstanding. An enqueue with a valid size while two are outstanding produces an `err_overflow` pulse in the next cycle, no programming pulse, and no change of state.
- R2: An accepted enqueue produces, in the next cycle, `prog_valid` with `prog_slot` equal to the submit pointer, `prog_addr` equal to the posted address and `prog_bd` equal to size minus one. The submit pointer starts at slot 0 after reset and toggles on every acceptance.
- R3: A completion is taken only when `slot_done` bit [k] is set and k is the slot the completion pointer names. The pointer starts at slot 0. A taken completion produces `clr_valid` with `clr_slot`=k in the next cycle, toggles the pointer and advances the request counter. A done bit on the other slot is not taken.
- R4: A service strobe acts only while the service counter differs from the request counter, and it then advances the service counter. With one or more buffers outstanding it lowers the outstanding count and raises `done_count` by one. With none outstanding it produces an `err_underflow` pulse and leaves `done_count` unchanged.
- R5: A detach of N buffers with N greater than `done_count` produces an `err_underflow` pulse and leaves the count unchanged. Otherwise it subtracts N in the next cycle.
- R6: `ready` is high exactly while fewer than two buffers are outstanding. After reset it is high and `done_count` is 0.
- R7: A size of zero is rejected in every mode. In control mode (`cfg_mode`=0) and asynchronous mode (`cfg_mode`=1), a size above `CA_MAX` (default 2048) is rejected. Rejection gives an `err_size` pulse, no programming pulse and no state change, and it takes priority over overflow.
- R8: In isochronous mode (`cfg_mode`=2), `cfg_unit` is the packet length. The size must not exceed `ISO_MAX` (default 8192) and must be a whole number n of packets with n of at least 2.
- R9: In synchronous mode (`cfg_mode`=3), `cfg_unit` is the bytes per frame. The size must not exceed `ISO_MAX` and must be a nonzero multiple of `cfg_unit` times `FRAMES` (default 16).
- R10: A done bit that arrives while no buffer is outstanding is ignored. It produces no clear pulse, does not move the completion pointer and does not change the request counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Transfer type: 0 control, 1 async, 2 isochronous, 3 synchronous |
| cfg_unit | input | SIZE_W | Packet length (isochronous) or bytes per frame (synchronous) |
| enq_valid | input | 1 | Enqueue request strobe |
| enq_addr | input | ADDR_W | Buffer address of the request |
| enq_size | input | SIZE_W | Buffer size in bytes |
| svc_step | input | 1 | Service strobe from the consumer |
| det_valid | input | 1 | Detach request strobe |
| det_num | input | DONE_W | Number of finished buffers to detach |
| slot_done | input | 2 | Done bit of each descriptor slot from the DMA engine |
| prog_valid | output | 1 | Slot programming pulse |
| prog_slot | output | 1 | Slot to program |
| prog_addr | output | ADDR_W | Address to program into the slot |
| prog_bd | output | SIZE_W | Size minus one to program into the slot |
| clr_valid | output | 1 | Pulse to clear the done, error and ready bits of a slot |
| clr_slot | output | 1 | Slot to clear |
| ready | output | 1 | Another buffer may be posted |
| done_count | output | DONE_W | Finished buffers not yet detached |
| err_size | output | 1 | Size rejected |
| err_overflow | output | 1 | Enqueue into a full channel |
| err_underflow | output | 1 | Service with nothing outstanding, or detach beyond the count |

## Verification
Every pulse output (`prog_*`, `clr_*`, the three error flags) is registered, so it is due exactly one clock edge after the input strobe that caused it. The level-derived `ready` and the `done_count` value also settle on that same edge. The bench changes inputs just after a falling edge, lets exactly one rising edge pass, and samples at the following falling edge. Each one-cycle pulse is therefore seen in the one sampling window where it is high. Absence checks, such as an ignored done bit or a rejected size, are sampled in that same window. State that could have moved is then observed through later strobes: the next slot programmed, the next clear, or the next service result.

// File: rtl/pp_trk_pkg.sv
package pp_trk_pkg;

  typedef enum logic [1:0] {
    MODE_CTRL  = 2'd0,
    MODE_ASYNC = 2'd1,
    MODE_ISOC  = 2'd2,
    MODE_SYNC  = 2'd3
  } chan_mode_e;

  // Size legality per transfer type; all operands widened to 32 bits.
  function automatic logic buf_size_ok(input chan_mode_e  mode,
                                       input int unsigned size,
                                       input int unsigned unit,
                                       input int unsigned ca_max,
                                       input int unsigned iso_max,
                                       input int unsigned frames);
    int unsigned grain;
    if (size == 0) return 1'b0;
    case (mode)
      MODE_CTRL, MODE_ASYNC: return size <= ca_max;
      MODE_ISOC: begin
        if (unit == 0 || size > iso_max) return 1'b0;
        return (size % unit == 0) && (size / unit >= 2);
      end
      default: begin
        grain = unit * frames;
        if (grain == 0 || size > iso_max) return 1'b0;
        return size % grain == 0;
      end
    endcase
  endfunction

endpackage

// File: rtl/pp_size_check.sv
module pp_size_check
  import pp_trk_pkg::*;
#(
  parameter int SIZE_W  = 16,
  parameter int CA_MAX  = 2048,
  parameter int ISO_MAX = 8192,
  parameter int FRAMES  = 16
) (
  input  logic [1:0]        mode,
  input  logic [SIZE_W-1:0] unit,
  input  logic [SIZE_W-1:0] size,
  output logic              size_ok
);
  localparam int unsigned CA_LIM  = CA_MAX;
  localparam int unsigned ISO_LIM = ISO_MAX;
  localparam int unsigned FR_CNT  = FRAMES;

  always_comb begin
    size_ok = buf_size_ok(chan_mode_e'(mode), 32'(size), 32'(unit),
                          CA_LIM, ISO_LIM, FR_CNT);
  end
endmodule

// File: rtl/pp_submit.sv
module pp_submit #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  output logic              prog_valid,
  output logic              prog_slot,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [SIZE_W-1:0] prog_bd
);
  logic sub_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sub_idx    <= 1'b0;
      prog_valid <= 1'b0;
      prog_slot  <= 1'b0;
      prog_addr  <= '0;
      prog_bd    <= '0;
    end else begin
      prog_valid <= take;
      if (take) begin
        prog_slot <= sub_idx;
        prog_addr <= addr;
        prog_bd   <= size - SIZE_W'(1);
        sub_idx   <= ~sub_idx;
      end
    end
  end

  AST_SLOTS_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_valid && $past(prog_valid)) |-> (prog_slot != $past(prog_slot))); // R2
endmodule

// File: rtl/pp_complete.sv
module pp_complete #(
  parameter int CTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       slot_done,
  input  logic             busy,
  output logic             clr_valid,
  output logic             clr_slot,
  output logic [CTR_W-1:0] req_cnt
);
  logic cmp_idx;
  logic hit;

  assign hit = busy && slot_done[cmp_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_idx   <= 1'b0;
      clr_valid <= 1'b0;
      clr_slot  <= 1'b0;
      req_cnt   <= '0;
    end else begin
      clr_valid <= hit;
      if (hit) begin
        clr_slot <= cmp_idx;
        cmp_idx  <= ~cmp_idx;
        req_cnt  <= req_cnt + CTR_W'(1);
      end
    end
  end

  AST_CLR_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |-> $past(slot_done) != 2'b00); // R3
endmodule

// File: rtl/pp_account.sv
module pp_account #(
  parameter int CTR_W  = 8,
  parameter int DONE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq_take,
  input  logic              svc_step,
  input  logic [CTR_W-1:0]  req_cnt,
  input  logic              det_valid,
  input  logic [DONE_W-1:0] det_num,
  output logic [1:0]        level,
  output logic [DONE_W-1:0] done_cnt,
  output logic              svc_unf,
  output logic              det_unf
);
  logic [CTR_W-1:0] svc_cnt;
  logic             svc_run, svc_dec, det_ok;

  assign svc_run = svc_step && (svc_cnt != req_cnt);
  assign svc_dec = svc_run && (level != 2'd0);
  assign svc_unf = svc_run && (level == 2'd0);
  assign det_ok  = det_valid && (det_num <= done_cnt);
  assign det_unf = det_valid && (det_num > done_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      svc_cnt  <= '0;
      level    <= 2'd0;
      done_cnt <= '0;
    end else begin
      if (svc_run) svc_cnt <= svc_cnt + CTR_W'(1);
      level    <= level + {1'b0, enq_take} - {1'b0, svc_dec};
      done_cnt <= done_cnt + DONE_W'(svc_dec) - (det_ok ? det_num : '0);
    end
  end

  AST_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    level <= 2'd2); // R1
  AST_DONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (done_cnt > $past(done_cnt)) |-> (done_cnt == $past(done_cnt) + DONE_W'(1))); // R4
endmodule

// File: rtl/pp_chan_tracker.sv
module pp_chan_tracker #(
  parameter int ADDR_W  = 32,
  parameter int SIZE_W  = 16,
  parameter int CA_MAX  = 2048,
  parameter int ISO_MAX = 8192,
  parameter int FRAMES  = 16,
  parameter int CTR_W   = 8,
  parameter int DONE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic [SIZE_W-1:0] cfg_unit,
  input  logic              enq_valid,
  input  logic [ADDR_W-1:0] enq_addr,
  input  logic [SIZE_W-1:0] enq_size,
  input  logic              svc_step,
  input  logic              det_valid,
  input  logic [DONE_W-1:0] det_num,
  input  logic [1:0]        slot_done,
  output logic              prog_valid,
  output logic              prog_slot,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [SIZE_W-1:0] prog_bd,
  output logic              clr_valid,
  output logic              clr_slot,
  output logic              ready,
  output logic [DONE_W-1:0] done_count,
  output logic              err_size,
  output logic              err_overflow,
  output logic              err_underflow
);
  localparam logic [1:0] FULL_LEVEL = 2'd2;

  logic             size_ok;
  logic             enq_take, ovf_evt, size_evt;
  logic [1:0]       level_q;
  logic [CTR_W-1:0] req_cnt;
  logic             svc_unf, det_unf;

  assign ready    = (level_q != FULL_LEVEL);
  assign size_evt = enq_valid && !size_ok;
  assign ovf_evt  = enq_valid && size_ok && !ready;
  assign enq_take = enq_valid && size_ok && ready;

  pp_size_check #(
    .SIZE_W(SIZE_W), .CA_MAX(CA_MAX), .ISO_MAX(ISO_MAX), .FRAMES(FRAMES)
  ) u_size (
    .mode(cfg_mode), .unit(cfg_unit), .size(enq_size), .size_ok(size_ok)
  );

  pp_submit #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_submit (
    .clk(clk), .rst_n(rst_n), .take(enq_take), .addr(enq_addr),
    .size(enq_size), .prog_valid(prog_valid), .prog_slot(prog_slot),
    .prog_addr(prog_addr), .prog_bd(prog_bd)
  );

  pp_complete #(.CTR_W(CTR_W)) u_complete (
    .clk(clk), .rst_n(rst_n), .slot_done(slot_done),
    .busy(level_q != 2'd0), .clr_valid(clr_valid), .clr_slot(clr_slot),
    .req_cnt(req_cnt)
  );

  pp_account #(.CTR_W(CTR_W), .DONE_W(DONE_W)) u_account (
    .clk(clk), .rst_n(rst_n), .enq_take(enq_take), .svc_step(svc_step),
    .req_cnt(req_cnt), .det_valid(det_valid), .det_num(det_num),
    .level(level_q), .done_cnt(done_count), .svc_unf(svc_unf),
    .det_unf(det_unf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_size      <= 1'b0;
      err_overflow  <= 1'b0;
      err_underflow <= 1'b0;
    end else begin
      err_size      <= size_evt;
      err_overflow  <= ovf_evt;
      err_underflow <= svc_unf || det_unf;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    prog_valid |-> $past(level_q) != FULL_LEVEL); // R1
  AST_SIZE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    err_size |-> !prog_valid && !err_overflow); // R7
  AST_CLR_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |-> $past(level_q) != 2'd0); // R10
endmodule

// File: tb/pp_chan_tracker_tb.sv
module pp_chan_tracker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic [15:0] cfg_unit = 16'd0;
  logic        enq_valid = 1'b0;
  logic [31:0] enq_addr = 32'd0;
  logic [15:0] enq_size = 16'd0;
  logic        svc_step = 1'b0;
  logic        det_valid = 1'b0;
  logic [7:0]  det_num = 8'd0;
  logic [1:0]  slot_done = 2'b00;
  logic        prog_valid, prog_slot, clr_valid, clr_slot, ready;
  logic [31:0] prog_addr;
  logic [15:0] prog_bd;
  logic [7:0]  done_count;
  logic        err_size, err_overflow, err_underflow;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit ended = 0;

  always #4 clk = ~clk;

  pp_chan_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_unit(cfg_unit),
    .enq_valid(enq_valid), .enq_addr(enq_addr), .enq_size(enq_size),
    .svc_step(svc_step), .det_valid(det_valid), .det_num(det_num),
    .slot_done(slot_done), .prog_valid(prog_valid), .prog_slot(prog_slot),
    .prog_addr(prog_addr), .prog_bd(prog_bd), .clr_valid(clr_valid),
    .clr_slot(clr_slot), .ready(ready), .done_count(done_count),
    .err_size(err_size), .err_overflow(err_overflow),
    .err_underflow(err_underflow)
  );

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      finish_run();
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] mode, input logic [15:0] unit);
    rst_n = 1'b0;
    cfg_mode = mode;
    cfg_unit = unit;
    slot_done = 2'b00;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  // One-cycle enqueue; results sampled one edge later.
  task automatic enq(input logic [31:0] a, input logic [15:0] s);
    enq_valid = 1'b1; enq_addr = a; enq_size = s;
    step();
    enq_valid = 1'b0;
  endtask

  task automatic expect_prog(string req, logic slot, logic [31:0] a, logic [15:0] bd);
    check(req, {31'd0, prog_valid}, 32'd1);
    check(req, {31'd0, prog_slot}, {31'd0, slot});
    check(req, prog_addr, a);
    check(req, {16'd0, prog_bd}, {16'd0, bd});
    check(req, {29'd0, err_size, err_overflow, err_underflow}, 32'd0);
  endtask

  task automatic expect_size_err(string req);
    check(req, {31'd0, err_size}, 32'd1);
    check(req, {31'd0, prog_valid}, 32'd0);
  endtask

  task automatic t_reset_state();
    do_reset(2'd0, 16'd0);
    check("R6 ready after reset", {31'd0, ready}, 32'd1);
    check("R6 done_count after reset", {24'd0, done_count}, 32'd0);
    check("R6 quiet after reset",
          {27'd0, prog_valid, clr_valid, err_size, err_overflow, err_underflow}, 32'd0);
  endtask

  task automatic t_control_flow();
    do_reset(2'd0, 16'd0);
    enq(32'h0000_1000, 16'd64);
    expect_prog("R2 first slot", 1'b0, 32'h0000_1000, 16'd63);
    check("R6 ready at one", {31'd0, ready}, 32'd1);
    enq(32'h0000_2000, 16'd100);
    expect_prog("R2 second slot", 1'b1, 32'h0000_2000, 16'd99);
    check("R6 not ready at two", {31'd0, ready}, 32'd0);
    enq(32'h0000_3000, 16'd32);
    check("R1 overflow pulse", {31'd0, err_overflow}, 32'd1);
    check("R1 no programming", {31'd0, prog_valid}, 32'd0);
    check("R1 still full", {31'd0, ready}, 32'd0);
    // wrong slot first
    slot_done = 2'b10; step();
    check("R3 other slot ignored", {31'd0, clr_valid}, 32'd0);
    slot_done = 2'b11; step();
    check("R3 clear slot0", {30'd0, clr_valid, clr_slot}, 32'd2);
    slot_done = 2'b10; step();
    check("R3 clear slot1", {30'd0, clr_valid, clr_slot}, 32'd3);
    slot_done = 2'b00; step();
    check("R3 no further clear", {31'd0, clr_valid}, 32'd0);
    svc_step = 1'b1; step();
    check("R4 first service", {24'd0, done_count}, 32'd1);
    check("R6 ready after service", {31'd0, ready}, 32'd1);
    step();
    check("R4 second service", {24'd0, done_count}, 32'd2);
    step();
    check("R4 counters equal no change", {24'd0, done_count}, 32'd2);
    check("R4 no underflow when idle", {31'd0, err_underflow}, 32'd0);
    svc_step = 1'b0;
    det_valid = 1'b1; det_num = 8'd3; step();
    check("R5 detach too many", {31'd0, err_underflow}, 32'd1);
    check("R5 count kept", {24'd0, done_count}, 32'd2);
    det_num = 8'd2; step();
    check("R5 detach ok", {24'd0, done_count}, 32'd0);
    check("R5 no error", {31'd0, err_underflow}, 32'd0);
    det_valid = 1'b0;
    // R10: done while nothing outstanding
    slot_done = 2'b01; step();
    check("R10 no clear when idle", {31'd0, clr_valid}, 32'd0);
    slot_done = 2'b00;
    svc_step = 1'b1; step();
    svc_step = 1'b0;
    check("R10 request counter unchanged", {24'd0, done_count}, 32'd0);
    check("R10 no underflow", {31'd0, err_underflow}, 32'd0);
    enq(32'h0000_4000, 16'd8);
    expect_prog("R2 wraps to slot0", 1'b0, 32'h0000_4000, 16'd7);
    slot_done = 2'b01; step();
    check("R10 pointer unmoved", {30'd0, clr_valid, clr_slot}, 32'd2);
    slot_done = 2'b00; step();
  endtask

  task automatic t_service_underflow();
    do_reset(2'd1, 16'd0);
    enq(32'h0000_0100, 16'd16);
    expect_prog("R2 async slot0", 1'b0, 32'h0000_0100, 16'd15);
    slot_done = 2'b01; step();
    check("R3 accept slot0", {30'd0, clr_valid, clr_slot}, 32'd2);
    slot_done = 2'b10; step();
    check("R3 accept slot1 while busy", {30'd0, clr_valid, clr_slot}, 32'd3);
    slot_done = 2'b00;
    svc_step = 1'b1; step();
    check("R4 retire one", {24'd0, done_count}, 32'd1);
    step();
    svc_step = 1'b0;
    check("R4 underflow at level zero", {31'd0, err_underflow}, 32'd1);
    check("R4 count unchanged on underflow", {24'd0, done_count}, 32'd1);
  endtask

  task automatic t_ctrl_sizes();
    do_reset(2'd0, 16'd0);
    enq(32'h10, 16'd0);
    expect_size_err("R7 zero size");
    enq(32'h20, 16'd2049);
    expect_size_err("R7 above control max");
    cfg_mode = 2'd1;
    enq(32'h30, 16'd2048);
    expect_prog("R7 async max accepted", 1'b0, 32'h30, 16'd2047);
  endtask

  task automatic t_isoc_sizes();
    do_reset(2'd2, 16'd188);
    enq(32'h40, 16'd188);
    expect_size_err("R8 single packet");
    enq(32'h41, 16'd377);
    expect_size_err("R8 partial packet");
    enq(32'h42, 16'd376);
    expect_prog("R8 two packets", 1'b0, 32'h42, 16'd375);
    enq(32'h43, 16'd564);
    expect_prog("R8 three packets", 1'b1, 32'h43, 16'd563);
    enq(32'h44, 16'd8272);
    expect_size_err("R8 above max beats overflow");
    check("R8 no overflow", {31'd0, err_overflow}, 32'd0);
  endtask

  task automatic t_sync_sizes();
    do_reset(2'd3, 16'd4);
    enq(32'h50, 16'd96);
    expect_size_err("R9 not a frame multiple");
    enq(32'h51, 16'd0);
    expect_size_err("R9 zero size");
    enq(32'h52, 16'd64);
    expect_prog("R9 one unit", 1'b0, 32'h52, 16'd63);
    enq(32'h53, 16'd128);
    expect_prog("R9 two units", 1'b1, 32'h53, 16'd127);
  endtask

  initial begin
    t_reset_state();
    t_control_flow();
    t_service_underflow();
    t_ctrl_sizes();
    t_isoc_sizes();
    t_sync_sizes();
    finish_run();
  end
endmodule